// File: doc/BRIEF.md
# Four-Bank Interleaved Block Fill Controller

This block serves cache line fills from four one-word-wide storage banks. Consecutive word addresses are spread across the banks: the two low bits of a word address pick the bank, and the remaining upper bits pick the row inside that bank. A fill request costs one cycle to broadcast the row to every bank. All four banks then run their fixed 15-cycle access together, and the four words are streamed back over a single one-word return path, one word per cycle. The whole four-word fill therefore completes in 20 cycles.

For comparison, a per-request serial timing mode is also provided. In this mode the banks are visited one at a time, and each word pays its own 15-cycle access plus one transfer cycle. This mimics a single non-interleaved bank and gives a 65-cycle fill. Single-word writes go only to the addressed bank and complete after one address cycle and one access. The controller takes a new request only while idle. Requests presented while it is busy are dropped.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: After synchronous active-low reset, and until the first request is accepted, `busy`, `rd_valid` and `done` are low.
- R2: A read request with `req_serial`=0 that is accepted at a clock edge keeps `busy` high for exactly 20 cycles, starting in the cycle after that edge (1 address + 15 access + 4 transfer).
- R3: In both read modes the four words of the block come back in order, with word k carried in the cycle where `rd_index`=k. The word at word address A is held in bank A mod 4 at row A div 4. In interleaved mode `rd_valid` is high in cycles 17, 18, 19 and 20 after acceptance.
- R4: A read request with `req_serial`=1 keeps `busy` high for 65 cycles. Word k appears with `rd_valid` in cycle 17+16k after acceptance.
- R5: `done` is a one-cycle pulse in the last busy cycle of every operation, and `busy` is low in the following cycle.
- R6: A write request (`req_write`=1) keeps `busy` high for 16 cycles and stores `req_wdata` only at word address `req_addr`. The other three words of that block are unchanged.
- R7: A request presented while `busy` is high is ignored. It neither changes the operation in progress nor writes storage.
- R8: A read fetches the aligned block that contains `req_addr`. The two low address bits do not affect the words returned or their order.
- R9: `rd_valid` is high only during read transfer cycles. It is never high during a write or while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_serial | input | 1 | 1 = one-bank-at-a-time read timing |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | High from the address cycle through the last cycle |
| rd_valid | output | 1 | Read word on `rd_data` is valid |
| rd_index | output | 2 | Word number within the block |
| rd_data | output | DATA_W | Returned read word |
| done | output | 1 | Pulse in the final cycle of an operation |

## Verification
Several properties are checked by assertions on every cycle:
- `rd_valid` implies `busy`.
- `done` lasts one cycle and is followed by idle.
- `busy` never drops before `done`.
- The access counter stays below the latency.
- At most one bank is written per cycle, and never while a bank is being read.
- Interleaved data cycles step the word index by one.
- The captured request stays stable while busy.

Some behaviour only the bench scenarios can show, because it needs a reference memory model: the exact 20, 65 and 16 cycle lengths, the position of each word, the returned data against that model, the isolation of neighbouring words on a write, and the dropping of a request injected mid-fill.

// File: rtl/ilv_pkg.sv
// Package: shared types for the interleaved fill controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ilv_pkg;

    // Controller phases: idle, address broadcast, bank access, word transfer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } ilv_state_e;

endpackage

// File: rtl/ilv_bank.sv
// Module: ilv_bank
// One word-wide storage bank with registered read data.
// The caller holds the fixed access latency; this model captures the row on
// the final access cycle (rd_en) or commits a write (wr_en).
// Assumes: rd_en and wr_en are never high together; contents are not reset.
module ilv_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit a write into the addressed row.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[row] <= wdata;
        end
    end

    // Latch the row contents at the end of a read access; hold otherwise.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata <= cells[row];
        end
    end

endmodule

// File: rtl/ilv_sequencer.sv
// Module: ilv_sequencer
// Request capture, address cycle, access latency counter and word ordering.
// Interleaved reads strobe every bank once; serial reads strobe one bank per
// word and repeat the access for each word. Writes strobe one bank.
// Assumes: NUM_BANKS is a power of two, LAT >= 2.
module ilv_sequencer
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int LAT       = 15,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W,
    localparam int CNT_W    = $clog2(LAT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_serial,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [BANK_W-1:0]    rd_index,
    output logic                 done,
    output logic [NUM_BANKS-1:0] bank_rd,
    output logic [NUM_BANKS-1:0] bank_wr,
    output logic [ROW_W-1:0]     bank_row,
    output logic [DATA_W-1:0]    bank_wdata
);
    ilv_state_e        state;
    logic [CNT_W-1:0]  lat_cnt;
    logic [BANK_W-1:0] word_idx;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] wdata_q;
    logic              op_write;
    logic              op_serial;
    logic              lat_last;
    logic              idx_last;

    // Final access cycle and final word flags.
    always_comb begin
        lat_last = (state == ST_ACCESS) && (lat_cnt == CNT_W'(LAT - 1));
        idx_last = (word_idx == BANK_W'(NUM_BANKS - 1));
    end

    // Phase sequencing, request capture and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_cnt   <= '0;
            word_idx  <= '0;
            bank_q    <= '0;
            row_q     <= '0;
            wdata_q   <= '0;
            op_write  <= 1'b0;
            op_serial <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_ADDR;
                        op_write  <= req_write;
                        op_serial <= req_serial;
                        row_q     <= req_addr[ADDR_W-1:BANK_W];
                        bank_q    <= req_addr[BANK_W-1:0];
                        wdata_q   <= req_wdata;
                        word_idx  <= '0;
                    end
                end
                ST_ADDR: begin
                    state   <= ST_ACCESS;
                    lat_cnt <= '0;
                end
                ST_ACCESS: begin
                    if (lat_last) begin
                        lat_cnt <= '0;
                        state   <= op_write ? ST_IDLE : ST_XFER;
                    end else begin
                        lat_cnt <= lat_cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (idx_last) begin
                        state    <= ST_IDLE;
                        word_idx <= '0;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        if (op_serial) begin
                            state <= ST_ACCESS;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-bank read and write strobes on the last access cycle.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        always_comb begin
            bank_rd[b] = lat_last && !op_write &&
                         (!op_serial || (word_idx == BANK_W'(b)));
            bank_wr[b] = lat_last && op_write && (bank_q == BANK_W'(b));
        end
    end

    // Status and data-path outputs.
    always_comb begin
        busy       = (state != ST_IDLE);
        rd_valid   = (state == ST_XFER);
        rd_index   = word_idx;
        done       = (lat_last && op_write) || (rd_valid && idx_last);
        bank_row   = row_q;
        bank_wdata = wdata_q;
    end

    assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_lat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |-> (lat_cnt < CNT_W'(LAT)));
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !done && !op_serial) |=>
            (rd_valid && rd_index == $past(rd_index) + 1'b1));
    assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(op_write) && $stable(row_q) && $stable(bank_q)));

endmodule

// File: rtl/ilv_fill_ctrl.sv
// Module: ilv_fill_ctrl (top)
// Four-bank word-interleaved fill controller: sequencer plus bank array and
// the return-word multiplexer.
// Assumes: word address low BANK_W bits select the bank.
module ilv_fill_ctrl #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int LAT       = 15,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_serial,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_index,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic [NUM_BANKS-1:0] bank_rd;
    logic [NUM_BANKS-1:0] bank_wr;
    logic [ROW_W-1:0]     bank_row;
    logic [DATA_W-1:0]    bank_wdata;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    ilv_sequencer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .LAT       (LAT)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_serial (req_serial),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_index   (rd_index),
        .done       (done),
        .bank_rd    (bank_rd),
        .bank_wr    (bank_wr),
        .bank_row   (bank_row),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) i_bank (
            .clk   (clk),
            .rd_en (bank_rd[b]),
            .wr_en (bank_wr[b]),
            .row   (bank_row),
            .wdata (bank_wdata),
            .rdata (bank_rdata[b])
        );
    end

    // Return-word multiplexer: the word index selects its bank.
    always_comb begin
        rd_data = bank_rdata[rd_index];
    end

    assert_single_bank_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));
    assert_no_rd_wr_mix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_wr) |-> !(|bank_rd));

endmodule

// File: tb/test_ilv_fill_ctrl.sv
`timescale 1ns/1ps
module test_ilv_fill_ctrl;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_serial = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy;
    logic          rd_valid;
    logic [1:0]    rd_index;
    logic [DW-1:0] rd_data;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [DW-1:0] ref_mem [32];

    always #2.5 clk = ~clk;

    ilv_fill_ctrl i_ilv_fill_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_serial(req_serial), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_data(rd_data), .done(done)
    );

    function automatic int exp_read_len(bit serial);
        return serial ? 1 + 4 * (15 + 1) : 1 + 15 + 4;
    endfunction

    function automatic int exp_word_cycle(bit serial, int k);
        return serial ? 1 + 16 * (k + 1) : 1 + 15 + 1 + k;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_word(int addr, logic [DW-1:0] data);
        int n = 0;
        int done_at = 0;
        int rdv = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_serial = 1'b0;
        req_addr = AW'(addr); req_wdata = data;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!busy || n > 200) break;
            n++;
            if (done) done_at = n;
            if (rd_valid) rdv++;
        end
        ref_mem[addr & 31] = data;
        chk("R6 write busy length", n, 16);
        chk("R5 write done cycle", done_at, 16);
        chk("R9 rd_valid during write", rdv, 0);
    endtask

    task automatic read_block(int addr, bit serial, bit inject);
        int n = 0;
        int done_at = 0;
        int k = 0;
        int base = addr & 28;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_serial = serial;
        req_addr = AW'(addr);
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!busy || n > 200) break;
            n++;
            if (inject && n == 3) begin
                // R7: request during busy, write to another block
                req_valid = 1'b1; req_write = 1'b1; req_serial = 1'b0;
                req_addr = AW'((addr + 8) & 31); req_wdata = 32'hDEAD_0000 | 32'(n);
            end
            if (done) done_at = n;
            if (rd_valid) begin
                chk(serial ? "R4 word cycle" : "R3 word cycle", n, exp_word_cycle(serial, k));
                chk("R3 word index", rd_index, k & 3);
                chk("R3/R8 word data", rd_data, ref_mem[(base + k) & 31]);
                k++;
            end
        end
        chk(serial ? "R4 serial busy length" : "R2 busy length", n, exp_read_len(serial));
        chk("R3 word count", k, 4);
        chk("R5 read done cycle", done_at, n);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 busy after reset", busy, 0);
            chk("R1 rd_valid after reset", rd_valid, 0);
            chk("R1 done after reset", done, 0);
        end
        for (int a = 0; a < 32; a++) write_word(a, $urandom);
        read_block(0, 1'b0, 1'b0);
        read_block(7, 1'b1, 1'b0);   // R8 low bits set, R4 serial
        read_block(9, 1'b0, 1'b1);   // R7 injected write to block at 16
        read_block(16, 1'b0, 1'b0);  // R7 block 16 untouched
        write_word(13, 32'hA5A5_0013);
        read_block(12, 1'b0, 1'b0);  // R6 neighbours of 13 unchanged
        read_block(30, 1'b1, 1'b1);  // R8, R4, R7 in serial mode
        for (int i = 0; i < 40; i++) begin
            int r = int'($urandom % 3);
            int a = int'($urandom % 32);
            if (r == 0) write_word(a, $urandom);
            else read_block(a, r == 2, ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule